// File: doc/BRIEF.md
# Priority-level interrupt controller

This block collects up to 32 interrupt lines into a pending register and masks that register with an enable register. It then reports the highest priority level whose lines are pending and enabled, provided that level lies strictly above the processor's present masking level. Each line is fixed by parameter as either level-sensitive or edge-sensitive. Each priority level owns a parameter bitmask that selects the lines belonging to it.

Software reaches the block through a small write port and a combinational read port. Register select 0 is the pending register: a read returns it, and a write clears edge-type bits (write one to clear). Register select 1 is the enable register, which can be read and written. The processor drives its current level on `cur_level`. The block drives a registered request flag and the number of the winning level. Levels are numbered from 1 to `NUM_LEVELS`. Level 0 means that nothing qualifies.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While a level-type line n below `NUM_ACTIVE` is high at a clock edge, pending bit n reads 1 after that edge.
- R2: When a level-type line is low at a clock edge, its pending bit reads 0 after that edge. A write to register select 0 does not change the bit.
- R3: An edge-type line sets its pending bit only on a 0-to-1 change between two consecutive edges. The bit stays set after the line falls. Holding the line high does not set the bit again once it has been cleared.
- R4: A write to register select 0 clears each edge-type pending bit whose data bit is 1. If a rising input arrives in the same cycle as the clear, the bit is set.
- R5: Register select 1 holds the enable register. A write takes effect at the next edge and reads back unchanged. Only pending bits whose enable bit is 1 take part in arbitration.
- R6: The winner is the highest level l, with l greater than `cur_level`, whose line mask shares a bit with pending AND enable. In that case `irq_level` is l and `irq_req` is 1.
- R7: When no level qualifies, `irq_level` is 0 and `irq_req` is 0.
- R8: Lines at index `NUM_ACTIVE` or above never set a pending bit, even when a level mask includes them.
- R9: The outputs are registered. A change in pending, enable or `cur_level` appears after the next clock edge. A line change therefore reaches the outputs two edges after it is sampled.
- R10: Reset clears pending, enable and both outputs asynchronously. All of them stay clear through the first two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Interrupt lines |
| cur_level | input | LVL_W | Current processor masking level |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 pending, 1 enable |
| reg_wr_data | input | NUM_IRQ | Write data |
| reg_rd_data | output | NUM_IRQ | Read data for the selected register |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | LVL_W | Winning level, 0 when none |

## Verification
The assertions assume that `irq_in` and `cur_level` are sampled only at clock edges and hold steady between them. They also assume that nothing is checked until one cycle after reset has released, because the pending and output properties compare against the previous cycle. The stimulus changes inputs only 2 ns after a rising edge and waits out the two-edge reset release before it checks. The level table uses level-type lines only, so that no edge-type bit carries over from one vector to the next.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;

  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_ENA  = 1'b1
  } reg_sel_e;

  // Mask of the lines below the configured count (count <= 32)
  function automatic logic [31:0] low_ones(input int count);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < count) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/prio_irq_pending.sv
`timescale 1ns/1ps
module prio_irq_pending #(
  parameter int NUM_IRQ    = 32,
  parameter int NUM_ACTIVE = 24,
  parameter logic [NUM_IRQ-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               clr_en,
  input  logic [NUM_IRQ-1:0] clr_mask,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [NUM_IRQ-1:0] prev_q
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    if (i >= NUM_ACTIVE) begin : g_off
      assign pend_q[i] = 1'b0;
      assign prev_q[i] = irq_in[i] & 1'b0;
    end else if (EDGE_MASK[i]) begin : g_edge
      logic pend_d;
      logic rise;
      always_comb begin
        rise   = irq_in[i] & ~prev_q[i];
        pend_d = rise | (pend_q[i] & ~(clr_en & clr_mask[i]));
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q[i] <= 1'b0;
          prev_q[i] <= 1'b0;
        end else begin
          pend_q[i] <= pend_d;
          prev_q[i] <= irq_in[i];
        end
      end
    end else begin : g_level
      logic pend_d;
      always_comb pend_d = irq_in[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q[i] <= 1'b0;
        end else begin
          pend_q[i] <= pend_d;
        end
      end
      assign prev_q[i] = pend_q[i];
    end
  end

endmodule

// File: rtl/prio_irq_resolve.sv
`timescale 1ns/1ps
module prio_irq_resolve #(
  parameter int NUM_IRQ    = 32,
  parameter int NUM_LEVELS = 6,
  parameter int LVL_W      = 3,
  parameter logic [NUM_LEVELS*NUM_IRQ-1:0] LEVEL_MASKS = '0
) (
  input  logic [NUM_IRQ-1:0] eff,
  input  logic [LVL_W-1:0]   cur_level,
  output logic [LVL_W-1:0]   win_level
);

  logic [NUM_LEVELS-1:0] hit;

  for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_lvl
    assign hit[l-1] = (|(eff & LEVEL_MASKS[(l-1)*NUM_IRQ +: NUM_IRQ]))
                      && (LVL_W'(l) > cur_level);
  end

  // Ascending scan: the last hit seen is the highest level
  always_comb begin
    win_level = '0;
    for (int l = 1; l <= NUM_LEVELS; l++) begin
      if (hit[l-1]) win_level = LVL_W'(l);
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int NUM_IRQ    = 32,
  parameter int NUM_ACTIVE = 24,
  parameter int NUM_LEVELS = 6,
  parameter logic [NUM_IRQ-1:0] EDGE_MASK = 32'hAAAA_AAAA,
  parameter logic [NUM_LEVELS*NUM_IRQ-1:0] LEVEL_MASKS = {
    32'hFFF0_0000, 32'h000F_0000, 32'h0000_F000,
    32'h0000_0F00, 32'h0000_00F0, 32'h0000_000F},
  localparam int LVL_W = $clog2(NUM_LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [LVL_W-1:0]   cur_level,
  input  logic               reg_wr_en,
  input  logic               reg_addr,
  input  logic [NUM_IRQ-1:0] reg_wr_data,
  output logic [NUM_IRQ-1:0] reg_rd_data,
  output logic               irq_req,
  output logic [LVL_W-1:0]   irq_level
);
  import prio_irq_pkg::*;

  // Reset: asynchronous assertion, release after two edges
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // Register access decode
  logic ena_we;
  logic clr_en;
  always_comb begin
    ena_we = reg_wr_en && (reg_sel_e'(reg_addr) == SEL_ENA);
    clr_en = reg_wr_en && (reg_sel_e'(reg_addr) == SEL_PEND);
  end

  // Enable register
  logic [NUM_IRQ-1:0] ena_q;
  logic [NUM_IRQ-1:0] ena_d;
  always_comb ena_d = ena_we ? reg_wr_data : ena_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ena_q <= '0;
    else             ena_q <= ena_d;
  end

  // Pending register
  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] prev_q;
  prio_irq_pending #(
    .NUM_IRQ    (NUM_IRQ),
    .NUM_ACTIVE (NUM_ACTIVE),
    .EDGE_MASK  (EDGE_MASK)
  ) u_pending (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .irq_in   (irq_in),
    .clr_en   (clr_en),
    .clr_mask (reg_wr_data),
    .pend_q   (pend_q),
    .prev_q   (prev_q)
  );

  assign reg_rd_data = (reg_sel_e'(reg_addr) == SEL_ENA) ? ena_q : pend_q;

  // Arbitration
  logic [NUM_IRQ-1:0] eff;
  logic [LVL_W-1:0]   win_level;
  assign eff = pend_q & ena_q;

  prio_irq_resolve #(
    .NUM_IRQ     (NUM_IRQ),
    .NUM_LEVELS  (NUM_LEVELS),
    .LVL_W       (LVL_W),
    .LEVEL_MASKS (LEVEL_MASKS)
  ) u_resolve (
    .eff       (eff),
    .cur_level (cur_level),
    .win_level (win_level)
  );

  // Output register
  logic             req_d;
  logic [LVL_W-1:0] lvl_d;
  always_comb begin
    lvl_d = win_level;
    req_d = (win_level != '0);
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
    end else begin
      irq_req   <= req_d;
      irq_level <= lvl_d;
    end
  end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
  parameter int NUM_IRQ    = 32,
  parameter int NUM_ACTIVE = 24,
  parameter int LVL_W      = 3,
  parameter logic [NUM_IRQ-1:0] EDGE_MASK = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_in,
  input logic [LVL_W-1:0]   cur_level,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_IRQ-1:0] prev_q,
  input logic [NUM_IRQ-1:0] ena_q,
  input logic               irq_req,
  input logic [LVL_W-1:0]   irq_level
);
  import prio_irq_pkg::*;

  localparam logic [NUM_IRQ-1:0] ACT_MASK = NUM_IRQ'(low_ones(NUM_ACTIVE));
  localparam logic [NUM_IRQ-1:0] EDGE_ACT = EDGE_MASK & ACT_MASK;
  localparam logic [NUM_IRQ-1:0] LVL_ACT  = ~EDGE_MASK & ACT_MASK;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_req_above_cur_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && irq_req) |-> (irq_level > $past(cur_level)));

  assert_inactive_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~ACT_MASK) == '0);

  assert_level_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pend_q & LVL_ACT) == ($past(irq_in) & LVL_ACT)));

  assert_edge_needs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pend_q & ~$past(pend_q) & EDGE_ACT & ~$past(irq_in & ~prev_q)) == '0));

  assert_no_enable_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ($past(ena_q) == '0)) |-> (!irq_req && irq_level == '0));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_IRQ    (NUM_IRQ),
  .NUM_ACTIVE (NUM_ACTIVE),
  .LVL_W      (LVL_W),
  .EDGE_MASK  (EDGE_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .irq_in    (irq_in),
  .cur_level (cur_level),
  .pend_q    (pend_q),
  .prev_q    (prev_q),
  .ena_q     (ena_q),
  .irq_req   (irq_req),
  .irq_level (irq_level)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic [31:0] irq_in;
  logic [2:0]  cur_level;
  logic        reg_wr_en;
  logic        reg_addr;
  logic [31:0] reg_wr_data;
  logic [31:0] reg_rd_data;
  logic        irq_req;
  logic [2:0]  irq_level;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  prio_irq_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_in      (irq_in),
    .cur_level   (cur_level),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .irq_req     (irq_req),
    .irq_level   (irq_level)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Lines 0..23 active; even lines level-type, odd lines edge-type.
  // Level l owns lines 4(l-1)..4(l-1)+3; level 6 also lists lines 24..31.
  localparam logic [31:0] ACT = 32'h00FF_FFFF;

  typedef struct packed {
    logic [31:0] irq;
    logic [31:0] en;
    logic [2:0]  cur;
    logic [2:0]  lvl;
    logic        req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{32'h0000_0001, 32'hFFFF_FFFF, 3'd0, 3'd1, 1'b1},
    '{32'h0000_0101, 32'hFFFF_FFFF, 3'd0, 3'd3, 1'b1},
    '{32'h0000_0101, 32'hFFFF_FFFF, 3'd3, 3'd0, 1'b0},
    '{32'h0000_0101, 32'hFFFF_FFFF, 3'd2, 3'd3, 1'b1},
    '{32'h0010_0004, 32'h0000_0004, 3'd0, 3'd1, 1'b1},
    '{32'h0010_0004, 32'hFFFF_FFFF, 3'd0, 3'd6, 1'b1},
    '{32'h0010_0004, 32'hFFFF_FFFF, 3'd6, 3'd0, 1'b0},
    '{32'h0100_0000, 32'hFFFF_FFFF, 3'd0, 3'd0, 1'b0},
    '{32'h0001_1000, 32'hFFFF_FFFF, 3'd4, 3'd5, 1'b1},
    '{32'h0001_1000, 32'h0000_1000, 3'd3, 3'd4, 1'b1},
    '{32'h0000_0000, 32'hFFFF_FFFF, 3'd0, 3'd0, 1'b0},
    '{32'h0005_0050, 32'h0000_0050, 3'd1, 3'd2, 1'b1}
  };

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] data);
    reg_wr_en   = 1'b1;
    reg_addr    = sel;
    reg_wr_data = data;
    tick();
    reg_wr_en   = 1'b0;
    reg_wr_data = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] data);
    reg_addr = sel;
    #1;
    data = reg_rd_data;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R9 actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; irq_in = '0; cur_level = '0;
    reg_wr_en = 1'b0; reg_addr = 1'b0; reg_wr_data = '0;
    tick(3);
    // Reset state R10
    check("R10 req in reset", {31'd0, irq_req}, 32'd0);
    check("R10 level in reset", {29'd0, irq_level}, 32'd0);
    rst_n = 1'b1;
    tick(3);
    rd(1'b0, d); check("R10 pending after reset", d, 32'd0);
    rd(1'b1, d); check("R10 enable after reset", d, 32'd0);

    // Table walk over level-type lines
    foreach (VECS[k]) begin
      wr(1'b1, VECS[k].en);
      irq_in = VECS[k].irq;
      cur_level = VECS[k].cur;
      tick(3);
      rd(1'b0, d); check($sformatf("R1/R2/R8 vec%0d pending", k), d, VECS[k].irq & ACT);
      check($sformatf("R6/R7 vec%0d level", k), {29'd0, irq_level}, {29'd0, VECS[k].lvl});
      check($sformatf("R6/R7 vec%0d req", k), {31'd0, irq_req}, {31'd0, VECS[k].req});
    end

    // Enable readback R5
    wr(1'b1, 32'hDEAD_BEEF);
    rd(1'b1, d); check("R5 enable readback", d, 32'hDEAD_BEEF);

    // Edge line 1 pulse: stays pending R3
    wr(1'b1, 32'hFFFF_FFFF);
    irq_in = '0; cur_level = '0; tick(3);
    irq_in = 32'h2; tick();
    irq_in = 32'h0; tick(2);
    rd(1'b0, d); check("R3 edge bit held after fall", d, 32'h2);
    check("R6 edge line wins level 1", {29'd0, irq_level}, 32'd1);

    // W1C clears edge bit, level bit untouched R4 / R2
    irq_in = 32'h1; tick(2);
    rd(1'b0, d); check("R4 before clear", d, 32'h3);
    wr(1'b0, 32'h3);
    rd(1'b0, d); check("R4/R2 clear edge keeps level", d, 32'h1);
    irq_in = 32'h0; tick(2);

    // Held-high edge line 3 does not re-set R3
    irq_in = 32'h8; tick(2);
    rd(1'b0, d); check("R3 edge set", d, 32'h8);
    wr(1'b0, 32'h8);
    rd(1'b0, d); check("R3 cleared while held", d, 32'h0);
    tick(3);
    rd(1'b0, d); check("R3 no re-set while held", d, 32'h0);
    irq_in = 32'h0; tick(2);

    // Rise and clear in same cycle: set wins R4
    irq_in = 32'h20;
    wr(1'b0, 32'h20);
    rd(1'b0, d); check("R4 rise beats clear", d, 32'h20);
    irq_in = 32'h0; tick();
    wr(1'b0, 32'h20); tick(2);

    // Inactive edge line 25 R8
    irq_in = 32'h0200_0000; tick();
    irq_in = 32'h0; tick(2);
    rd(1'b0, d); check("R8 inactive edge line", d, 32'h0);
    check("R8 no request", {31'd0, irq_req}, 32'd0);

    // Latency R9
    irq_in = 32'h1; tick();
    rd(1'b0, d); check("R9 pending after one edge", d, 32'h1);
    check("R9 req not yet", {31'd0, irq_req}, 32'd0);
    tick();
    check("R9 req after two edges", {31'd0, irq_req}, 32'd1);
    cur_level = 3'd1; tick();
    check("R9 cur_level one edge", {31'd0, irq_req}, 32'd0);
    cur_level = 3'd0; tick();
    check("R9 cur_level drop", {29'd0, irq_level}, 32'd1);

    // Mid-run reset R10
    rst_n = 1'b0; #1;
    check("R10 async req clear", {31'd0, irq_req}, 32'd0);
    rd(1'b1, d); check("R10 async enable clear", d, 32'd0);
    tick();
    rst_n = 1'b1;
    tick(2);
    rd(1'b0, d); check("R10 held two edges", d, 32'h0);
    tick();
    rd(1'b0, d); check("R10 runs after release", d, 32'h1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule